// File: doc/BRIEF.md
# OLED Panel Power-Up Sequencer

This block brings a small page-organised dot-matrix OLED panel out of reset without software help. It streams a fixed run of configuration command bytes to a byte-wide serial transmitter and holds the command/data select low while it does so. It then clears the panel memory one page at a time. Each page starts with a three-byte addressing preamble sent in command mode. A run of zero data bytes follows, sent with the select high.

Bytes leave through a valid/ready handshake. A byte is consumed only on a clock edge where both `tx_valid` and `tx_ready` are high. The byte and its select do not change while the transmitter stalls. When the last zero byte of the last page has been accepted, the block gives a one-cycle `done` pulse and goes idle. A `start` pulse while idle runs the whole sequence again from its first byte.

Top module: `oled_boot_seq`

## Requirements
- R1: After reset is released, and after an accepted `start`, the first byte offered is 0xAE with `tx_is_data` = 0, and `tx_valid` is high.
- R2: The configuration phase sends exactly 31 bytes with `tx_is_data` = 0, in this order: AE, D5 10, A8 1F, D3 00, 40, AD, 8E, 20 02, A0, C8, DA 12, 91 3F 3F 3F 3F, 81 FF, 82 FF, D9 D2, DB 08, A4, A6.
- R3: A byte is consumed only on an edge where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_byte` and `tx_is_data` hold their values into the next cycle.
- R4: Each page clear opens with three bytes sent with `tx_is_data` = 0: 0xB0 plus the page number, then 0x00, then 0x10.
- R5: After each page preamble, exactly 132 bytes of value 0x00 are sent with `tx_is_data` = 1. `tx_is_data` is high only for these bytes.
- R6: Pages are cleared in ascending order from 0 to 7.
- R7: `done` is high for exactly one cycle, the cycle right after the edge that accepts the final zero byte of page 7. From then until the next `start` or reset, `tx_valid` and `done` stay low.
- R8: `start` is ignored while a sequence is running. The byte stream continues unchanged.
- R9: One full sequence consists of exactly 31 + 8 × 135 = 1111 accepted bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts a sequence |
| start | input | 1 | Re-run request, honoured only while idle |
| tx_ready | input | 1 | Transmitter can take a byte this cycle |
| tx_valid | output | 1 | A byte is offered on `tx_byte` |
| tx_byte | output | DATA_W (8) | Byte offered to the transmitter |
| tx_is_data | output | 1 | Select line: 0 = command byte, 1 = display data byte |
| done | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
The hold assertion assumes the transmitter may drop `tx_ready` for any number of cycles but never takes a byte unless `tx_valid` is high. The page and offset assertions assume that only the handshake advances the walk. The bench therefore drives `tx_ready` from three patterns: always ready, alternate cycles, and a pseudo-random pattern. It changes `tx_ready` only away from the active edge. It also raises `start` in the middle of a run and applies reset in the middle of a run. Because reset is asynchronous and the assertions are disabled while it is low, the mid-run reset never puts a property in a false state.

// File: rtl/oled_boot_pkg.sv
package oled_boot_pkg;

   // Number of command bytes in the fixed configuration list.
   localparam int CFG_LEN = 31;

   // Sequencer phase.
   typedef enum logic [1:0] {
      PH_CFG  = 2'd0,
      PH_CLR  = 2'd1,
      PH_IDLE = 2'd2
   } phase_e;

   // Configuration command list. Multi-byte commands keep their argument
   // bytes directly after the opcode.
   function automatic logic [7:0] cfg_byte(input logic [4:0] idx);
      logic [7:0] b;
      case (idx)
         5'd0:  b = 8'hAE;   // panel off
         5'd1:  b = 8'hD5;   // clock divide / oscillator
         5'd2:  b = 8'h10;
         5'd3:  b = 8'hA8;   // multiplex ratio
         5'd4:  b = 8'h1F;
         5'd5:  b = 8'hD3;   // vertical offset
         5'd6:  b = 8'h00;
         5'd7:  b = 8'h40;   // start line zero
         5'd8:  b = 8'hAD;   // supply configuration
         5'd9:  b = 8'h8E;
         5'd10: b = 8'h20;   // addressing mode
         5'd11: b = 8'h02;   // page mode
         5'd12: b = 8'hA0;   // column map normal
         5'd13: b = 8'hC8;   // row scan reversed
         5'd14: b = 8'hDA;   // row pin layout
         5'd15: b = 8'h12;
         5'd16: b = 8'h91;   // drive pulse widths, four arguments
         5'd17: b = 8'h3F;
         5'd18: b = 8'h3F;
         5'd19: b = 8'h3F;
         5'd20: b = 8'h3F;
         5'd21: b = 8'h81;   // contrast
         5'd22: b = 8'hFF;
         5'd23: b = 8'h82;   // area brightness
         5'd24: b = 8'hFF;
         5'd25: b = 8'hD9;   // precharge phases
         5'd26: b = 8'hD2;
         5'd27: b = 8'hDB;   // deselect level
         5'd28: b = 8'h08;
         5'd29: b = 8'hA4;   // show memory content
         5'd30: b = 8'hA6;   // non-inverted
         default: b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/oled_cfg_rom.sv
module oled_cfg_rom
   import oled_boot_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 5
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] byte_o,
   output logic              last_o
);

   localparam int LAST_IDX = CFG_LEN - 1;

   generate
      if (IDX_W < $clog2(CFG_LEN)) begin : g_bad_idx
         $error("oled_cfg_rom: IDX_W too small for the command list");
      end
      if (DATA_W != 8) begin : g_bad_w
         $error("oled_cfg_rom: command bytes are eight bits wide");
      end
   endgenerate

   logic [4:0] rom_idx;
   logic [7:0] rom_byte;

   // The index is narrowed or widened to the five-bit table index.
   generate
      if (IDX_W >= 5) begin : g_idx_wide
         assign rom_idx = idx[4:0];
      end else begin : g_idx_narrow
         assign rom_idx = {{(5-IDX_W){1'b0}}, idx};
      end
   endgenerate

   assign rom_byte = cfg_byte(rom_idx);
   assign byte_o   = DATA_W'(rom_byte);
   assign last_o   = (idx == IDX_W'(LAST_IDX));

   // The index never points past the list while it is read.
   always_comb begin
      AST_ROM_INDEX: assert ($isunknown(idx) || idx <= IDX_W'(LAST_IDX)); // R2
   end

endmodule

// File: rtl/oled_page_walker.sv
module oled_page_walker #(
   parameter int         N_PAGES       = 8,
   parameter int         PAGE_BYTES    = 132,
   parameter int         DATA_W        = 8,
   parameter logic [7:0] PAGE_CMD_BASE = 8'hB0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   output logic [DATA_W-1:0] byte_o,
   output logic              is_data_o,
   output logic              last_o
);

   localparam int PRE_LEN = 3;
   localparam int SPAN    = PAGE_BYTES + PRE_LEN;
   localparam int OFF_W   = $clog2(SPAN);
   localparam int PG_W    = (N_PAGES > 1) ? $clog2(N_PAGES) : 1;

   localparam logic [7:0] COL_LO_CMD = 8'h00;
   localparam logic [7:0] COL_HI_CMD = 8'h10;

   generate
      if (N_PAGES < 1 || N_PAGES > 16) begin : g_bad_pages
         $error("oled_page_walker: N_PAGES must be 1..16");
      end
      if (PAGE_BYTES < 1) begin : g_bad_bytes
         $error("oled_page_walker: PAGE_BYTES must be positive");
      end
   endgenerate

   logic [OFF_W-1:0] off_q;
   logic [PG_W-1:0]  pg;
   logic             wrap;
   logic             last_page;

   assign wrap = (off_q == OFF_W'(SPAN - 1));

   // Offset within a page: three preamble bytes, then the zero fill.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= '0;
      end else if (clear) begin
         off_q <= '0;
      end else if (step) begin
         off_q <= wrap ? '0 : off_q + OFF_W'(1);
      end
   end

   // Page counter: only present when there is more than one page.
   generate
      if (N_PAGES > 1) begin : g_multi_page
         logic [PG_W-1:0] pg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pg_q <= '0;
            end else if (clear) begin
               pg_q <= '0;
            end else if (step && wrap) begin
               pg_q <= (pg_q == PG_W'(N_PAGES - 1)) ? '0 : pg_q + PG_W'(1);
            end
         end
         assign pg = pg_q;

         AST_PAGE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !clear && wrap && pg_q != PG_W'(N_PAGES - 1))
               |=> (pg_q == $past(pg_q) + PG_W'(1))); // R6
         AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            pg_q <= PG_W'(N_PAGES - 1)); // R6
      end else begin : g_single_page
         assign pg = '0;
      end
   endgenerate

   assign last_page = (pg == PG_W'(N_PAGES - 1));
   assign last_o    = last_page && wrap;
   assign is_data_o = (off_q >= OFF_W'(PRE_LEN));

   // Byte selection for the current offset.
   always_comb begin
      byte_o = '0;
      if (off_q == OFF_W'(0)) begin
         byte_o = DATA_W'(PAGE_CMD_BASE) | DATA_W'(pg);
      end else if (off_q == OFF_W'(1)) begin
         byte_o = DATA_W'(COL_LO_CMD);
      end else if (off_q == OFF_W'(2)) begin
         byte_o = DATA_W'(COL_HI_CMD);
      end else begin
         byte_o = '0;
      end
   end

   AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      off_q <= OFF_W'(SPAN - 1)); // R5
   AST_OFF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && wrap) |=> (off_q == '0)); // R4

endmodule

// File: rtl/oled_boot_seq.sv
module oled_boot_seq
   import oled_boot_pkg::*;
#(
   parameter int         DATA_W        = 8,
   parameter int         N_PAGES       = 8,
   parameter int         PAGE_BYTES    = 132,
   parameter logic [7:0] PAGE_CMD_BASE = 8'hB0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_byte,
   output logic              tx_is_data,
   output logic              done
);

   localparam int CFG_IW = $clog2(CFG_LEN);

   generate
      if (DATA_W != 8) begin : g_bad_w
         $error("oled_boot_seq: DATA_W must be 8");
      end
   endgenerate

   phase_e            phase_q, phase_d;
   logic [CFG_IW-1:0] cfg_idx_q, cfg_idx_d;
   logic              done_q, done_d;
   logic              accept;
   logic              restart;

   logic [DATA_W-1:0] rom_byte;
   logic              rom_last;
   logic [DATA_W-1:0] walk_byte;
   logic              walk_is_data;
   logic              walk_last;

   oled_cfg_rom #(
      .DATA_W (DATA_W),
      .IDX_W  (CFG_IW)
   ) u_rom (
      .idx    (cfg_idx_q),
      .byte_o (rom_byte),
      .last_o (rom_last)
   );

   oled_page_walker #(
      .N_PAGES       (N_PAGES),
      .PAGE_BYTES    (PAGE_BYTES),
      .DATA_W        (DATA_W),
      .PAGE_CMD_BASE (PAGE_CMD_BASE)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (restart),
      .step      (accept && phase_q == PH_CLR),
      .byte_o    (walk_byte),
      .is_data_o (walk_is_data),
      .last_o    (walk_last)
   );

   assign tx_valid = (phase_q != PH_IDLE);
   assign accept   = tx_valid && tx_ready;
   assign restart  = (phase_q == PH_IDLE) && start;

   // Output selection: configuration bytes come from the list and clear
   // bytes from the page walker.
   always_comb begin
      tx_byte    = '0;
      tx_is_data = 1'b0;
      case (phase_q)
         PH_CFG: begin
            tx_byte    = rom_byte;
            tx_is_data = 1'b0;
         end
         PH_CLR: begin
            tx_byte    = walk_byte;
            tx_is_data = walk_is_data;
         end
         default: begin
            tx_byte    = '0;
            tx_is_data = 1'b0;
         end
      endcase
   end

   // Next-state logic. Nothing moves unless a byte is accepted, except
   // that a restart is taken from idle.
   always_comb begin
      phase_d   = phase_q;
      cfg_idx_d = cfg_idx_q;
      done_d    = 1'b0;
      case (phase_q)
         PH_CFG: begin
            if (accept) begin
               if (rom_last) begin
                  phase_d   = PH_CLR;
                  cfg_idx_d = '0;
               end else begin
                  cfg_idx_d = cfg_idx_q + CFG_IW'(1);
               end
            end
         end
         PH_CLR: begin
            if (accept && walk_last) begin
               phase_d = PH_IDLE;
               done_d  = 1'b1;
            end
         end
         default: begin
            if (start) begin
               phase_d   = PH_CFG;
               cfg_idx_d = '0;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_CFG;
         cfg_idx_q <= '0;
         done_q    <= 1'b0;
      end else begin
         phase_q   <= phase_d;
         cfg_idx_q <= cfg_idx_d;
         done_q    <= done_d;
      end
   end

   assign done = done_q;

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_is_data))); // R3
   AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_is_data) |-> (tx_byte == '0)); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !tx_valid); // R7
   AST_CFG_IS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CFG) |-> !tx_is_data); // R2
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && start && !tx_ready) |=> $stable(tx_byte)); // R8

endmodule

// File: tb/tb_oled_boot_seq.sv
module tb_oled_boot_seq;

   localparam int CLK_P     = 10;
   localparam int CFG_N     = 31;
   localparam int SPAN      = 135;
   localparam int PAGES     = 8;
   localparam int TOTAL     = CFG_N + PAGES * SPAN;
   localparam int RUN_LIMIT = 20 * TOTAL;

   // Expected configuration bytes.
   localparam logic [7:0] CFG_EXP [CFG_N] = '{
      8'hAE, 8'hD5, 8'h10, 8'hA8, 8'h1F, 8'hD3, 8'h00, 8'h40,
      8'hAD, 8'h8E, 8'h20, 8'h02, 8'hA0, 8'hC8, 8'hDA, 8'h12,
      8'h91, 8'h3F, 8'h3F, 8'h3F, 8'h3F, 8'h81, 8'hFF, 8'h82,
      8'hFF, 8'hD9, 8'hD2, 8'hDB, 8'h08, 8'hA4, 8'hA6 };

   // Run plan: ready pattern (0 always, 1 alternate, 2 pseudo-random)
   // and the byte index at which start is raised while busy (-1 = never).
   localparam int N_RUNS = 4;
   localparam int RUN_MODE  [N_RUNS] = '{0, 1, 2, 2};
   localparam int RUN_BUSYK [N_RUNS] = '{-1, 40, 600, 1105};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       tx_ready = 1'b0;
   logic       tx_valid;
   logic [7:0] tx_byte;
   logic       tx_is_data;
   logic       done;

   int         n_chk = 0;
   int         n_bad = 0;
   logic [7:0] lfsr = 8'h5A;

   always #(CLK_P/2) clk = ~clk;

   oled_boot_seq dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .tx_ready   (tx_ready),
      .tx_valid   (tx_valid),
      .tx_byte    (tx_byte),
      .tx_is_data (tx_is_data),
      .done       (done)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic void exp_at(input int k, output logic [7:0] b, output logic d,
                                  output string req);
      int j, p, o;
      if (k < CFG_N) begin
         b = CFG_EXP[k]; d = 1'b0; req = "R2 config byte";
      end else begin
         j = k - CFG_N; p = j / SPAN; o = j % SPAN;
         if (o == 0) begin
            b = 8'hB0 + 8'(p); d = 1'b0; req = "R4 R6 page select";
         end else if (o == 1) begin
            b = 8'h00; d = 1'b0; req = "R4 column low";
         end else if (o == 2) begin
            b = 8'h10; d = 1'b0; req = "R4 column high";
         end else begin
            b = 8'h00; d = 1'b1; req = "R5 zero fill";
         end
      end
   endfunction

   // Runs one full sequence; the caller is positioned at a falling edge.
   task automatic run_seq(input int mode, input int busy_k);
      int         k = 0;
      int         cyc = 0;
      logic       held = 1'b0;
      logic [7:0] h_byte = 8'h00;
      logic       h_dat = 1'b0;
      logic       r;
      logic [7:0] eb;
      logic       ed;
      string      rq;
      chk(tx_valid && tx_byte == 8'hAE && !tx_is_data, "R1 first byte",
          {tx_valid, tx_is_data, tx_byte}, {2'b10, 8'hAE});
      while (k < TOTAL && cyc < RUN_LIMIT) begin
         if (held) begin
            chk(tx_valid && tx_byte == h_byte && tx_is_data == h_dat, "R3 stall hold",
                {tx_valid, tx_is_data, tx_byte}, {1'b1, h_dat, h_byte});
         end
         chk(!done, "R7 no early done", done, 0);
         case (mode)
            0:       r = 1'b1;
            1:       r = cyc[0];
            default: r = lfsr[0] | lfsr[3];
         endcase
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         start = (k == busy_k);
         tx_ready = r;
         held = tx_valid && !r;
         h_byte = tx_byte;
         h_dat = tx_is_data;
         if (tx_valid && r) begin
            exp_at(k, eb, ed, rq);
            chk(tx_byte == eb && tx_is_data == ed, rq,
                {tx_is_data, tx_byte}, {ed, eb});
            k++;
         end
         cyc++;
         @(negedge clk);
      end
      start = 1'b0;
      chk(k == TOTAL, "R9 byte count", k, TOTAL);
      chk(done && !tx_valid, "R7 done after last byte", {done, tx_valid}, 2'b10);
      tx_ready = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(!done && !tx_valid, "R7 idle quiet", {done, tx_valid}, 2'b00);
      end
      tx_ready = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_bad++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // Reset state.
      repeat (3) @(negedge clk);
      chk(!done, "R7 done low in reset", done, 0);
      rst_n = 1'b1;

      // Walk the run plan.
      for (int i = 0; i < N_RUNS; i++) begin
         if (i != 0) pulse_start();
         run_seq(RUN_MODE[i], RUN_BUSYK[i]);
      end

      // Start with the transmitter stalled: first byte held for several cycles.
      pulse_start();
      for (int i = 0; i < 5; i++) begin
         chk(tx_valid && tx_byte == 8'hAE && !tx_is_data, "R1 R3 stalled first byte",
             {tx_valid, tx_is_data, tx_byte}, {2'b10, 8'hAE});
         @(negedge clk);
      end

      // Reset in the middle of a run, then a full run from the first byte.
      tx_ready = 1'b1;
      repeat (200) @(negedge clk);
      tx_ready = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk(!done, "R7 done low in mid-run reset", done, 0);
      rst_n = 1'b1;
      run_seq(0, 5);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule